// File: doc/BRIEF.md
# Ripple-Clocked Binary Down Counter

This block is a binary down counter made of a chain of toggle stages, one stage per count bit, each with its toggle input held at 1. Only the least significant stage is clocked by the system clock. Every later stage takes its clock from the output of the stage below it and toggles when that output rises. Because a stage output that rises from 0 to 1 marks a borrow out of the lower bits, the chain counts downwards and wraps from 0 to the all-ones code without stopping.

An active-low clear input resets every stage to zero at once, without waiting for a clock edge, and overrides clocking while it is held. A combinational decoder also presents the count as a one-hot vector. In steady state exactly one of its bits is high, so any intermediate codes that appear while a borrow ripples up the chain show up plainly on that vector. The logic has no delays of its own. The stages settle in order within the same clock cycle, and the outputs are only meaningful once the ripple has finished.

Top module: `ripple_down_counter`

## Requirements
- R1: While `clr_n` is low, `count` reads 0 and `count_onehot` has only bit 0 set.
- R2: With `clr_n` high, bit 0 of `count` inverts on every rising edge of `clk`.
- R3: With `clr_n` high, the settled `count` after each rising edge of `clk` equals the settled value before it minus 1, modulo 2^WIDTH.
- R4: A rising edge of `clk` taken at count 0 gives the all-ones code, 15 at the default width, with every bit changing.
- R5: Rising edges of `clk` that arrive while `clr_n` is low leave `count` at 0. The first rising edge after `clr_n` goes high produces the all-ones code.
- R6: Driving `clr_n` low forces `count` to 0 before the next rising edge of `clk`, with no clock edge needed. This holds even for a pulse that begins and ends between two edges.
- R7: Stage i (i ≥ 1) changes only when stage i-1 goes from 0 to 1. On an edge taken with bit 0 equal to 1, bits WIDTH-1 down to 1 stay unchanged.
- R8: In steady state `count_onehot` has exactly one bit set, and that bit sits at the index equal to `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the least significant stage; rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low; overrides clocking |
| count | output | WIDTH (4) | Current count, bit i being the output of stage i |
| count_onehot | output | 2^WIDTH (16) | One-hot view of the count; bit k is high when count equals k |

## Verification
Clearing and counting meet in the same cycle when `clr_n` is low across a rising edge of `clk`, and again when `clr_n` goes high shortly before an edge. The bench provokes both cases. It judges them with a behavioural model in which clear always wins, and which predicts exactly 0 during the clear and the all-ones code on the first edge after it. A short clear pulse that falls entirely between two edges tests the asynchronous path on its own. It is judged by sampling the count before the next edge and then checking that counting resumes from the all-ones code.

// File: rtl/rdc_pkg.sv
// Package: shared defaults and helpers for the ripple-clocked down counter.
// Assumes: widths are small enough that 2**width fits an int.
package rdc_pkg;

    // Default number of toggle stages in the chain.
    parameter int unsigned RDC_WIDTH_DEF = 4;

    // Number of one-hot outputs implied by a given stage count.
    function automatic int unsigned rdc_onehot_width(input int unsigned w);
        return 32'd1 << w;
    endfunction

endpackage

// File: rtl/rdc_toggle_stage.sv
// Module: one toggle flip-flop of the ripple chain.
// What it does: inverts its output on each rising edge of its own clock when
//   the toggle input is 1, and drops to 0 at once while clear is low.
// Assumes: stg_clk may come from another flop's output (ripple clocking);
//   clear is asynchronous and has priority over the clock.
module rdc_toggle_stage (
    input  logic stg_clk,
    input  logic clr_n,
    input  logic tgl,
    output logic q
);

    // Toggle register with asynchronous active-low clear.
    always_ff @(posedge stg_clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            q <= q ^ tgl;
        end
    end

endmodule

// File: rtl/rdc_onehot_dec.sv
// Module: binary-to-one-hot decoder for observing the count.
// What it does: sets output bit k when the input code equals k.
// Assumes: purely combinational; it shows any transient code it is given.
module rdc_onehot_dec #(
    parameter int unsigned CODE_W = 4,
    localparam int unsigned OH_W  = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [OH_W-1:0]   oh_o
);

    // One comparator per output line.
    for (genvar k = 0; k < OH_W; k++) begin : g_line
        assign oh_o[k] = (code_i == CODE_W'(k));
    end

endmodule

// File: rtl/ripple_down_counter.sv
// Module: ripple-clocked binary down counter (top).
// What it does: a chain of WIDTH toggle stages; stage 0 is clocked by clk and
//   stage i by the rising output of stage i-1, which counts downwards with
//   wrap-around. A decoder provides a one-hot view of the count.
// Assumes: clr_n is an asynchronous active-low clear; outputs are only valid
//   once the ripple has settled after a clk edge.
module ripple_down_counter #(
    parameter int unsigned WIDTH = rdc_pkg::RDC_WIDTH_DEF,
    localparam int unsigned OH_W = 1 << WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    output logic [WIDTH-1:0] count,
    output logic [OH_W-1:0]  count_onehot
);

    logic [WIDTH-1:0] stg_q;
    logic [WIDTH-1:0] stg_clk;

    // Build the clock chain and the toggle stages.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign stg_clk[i] = clk;
        end else begin : g_rest
            assign stg_clk[i] = stg_q[i-1];
        end

        rdc_toggle_stage u_stage (
            .stg_clk (stg_clk[i]),
            .clr_n   (clr_n),
            .tgl     (1'b1),
            .q       (stg_q[i])
        );
    end

    assign count = stg_q;

    // Observation decoder on the count.
    rdc_onehot_dec #(
        .CODE_W (WIDTH)
    ) u_dec (
        .code_i (stg_q),
        .oh_o   (count_onehot)
    );

endmodule

// File: rtl/ripple_down_counter_chk.sv
// Module: assertion checker bound to ripple_down_counter.
// What it does: samples settled outputs on clk edges and checks the counting
//   rules; a local flag marks any clear seen since the previous edge.
// Assumes: the ripple settles well within one clk period.
module ripple_down_counter_chk #(
    parameter int unsigned WIDTH = 4,
    localparam int unsigned OH_W = 1 << WIDTH
) (
    input logic             clk,
    input logic             clr_n,
    input logic [WIDTH-1:0] count,
    input logic [OH_W-1:0]  count_onehot
);

    logic clr_hit;

    // Remember a clear that occurred since the last clk edge.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            clr_hit <= 1'b1;
        end else begin
            clr_hit <= 1'b0;
        end
    end

    // R1 / R6: clear holds the count at zero.
    a_r1_clear_zero: assert property (@(posedge clk)
        !clr_n |-> (count == '0));

    // R2: least significant bit inverts on every counted edge.
    a_r2_lsb_toggle: assert property (@(posedge clk) disable iff (!clr_n)
        !clr_hit |-> (count[0] != $past(count[0])));

    // R3: settled count steps down by one, modulo 2^WIDTH.
    a_r3_down_step: assert property (@(posedge clk) disable iff (!clr_n)
        !clr_hit |-> (count == WIDTH'($past(count) - 1'b1)));

    // R7: upper stages hold when bit 0 was 1 before the edge.
    a_r7_upper_hold: assert property (@(posedge clk) disable iff (!clr_n)
        (!clr_hit && $past(count[0])) |-> (count[WIDTH-1:1] == $past(count[WIDTH-1:1])));

    // R8: one-hot view has a single bit set at the count index.
    a_r8_onehot_one: assert property (@(posedge clk)
        ($countones(count_onehot) == 1) && count_onehot[count]);

endmodule

bind ripple_down_counter ripple_down_counter_chk #(
    .WIDTH (WIDTH)
) chk_i (
    .clk          (clk),
    .clr_n        (clr_n),
    .count        (count),
    .count_onehot (count_onehot)
);

// File: tb/ripple_down_counter_tb_top.sv
`timescale 1ns/100ps
// Bench: behavioural reference model compared on every clock cycle.
module ripple_down_counter_tb_top;

    localparam int W    = 4;
    localparam int OH   = 1 << W;
    localparam int MODV = 1 << W;

    logic          clk = 1'b0;
    logic          clr_n = 1'b1;
    logic [W-1:0]  count;
    logic [OH-1:0] count_onehot;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int cyc = 0;
    bit done = 1'b0;

    ripple_down_counter #(.WIDTH(W)) dut_i (
        .clk          (clk),
        .clr_n        (clr_n),
        .count        (count),
        .count_onehot (count_onehot)
    );

    // 250 MHz clock.
    always #2 clk = ~clk;

    // Reference model: clear wins, else step down modulo 2^W.
    always @(posedge clk) begin
        int nxt;
        if (!clr_n) nxt = 0;
        else nxt = (exp_q[$] + MODV - 1) % MODV;
        exp_q.push_back(nxt);
        if (exp_q.size() > 8) void'(exp_q.pop_front());
    end

    always @(negedge clr_n) begin
        exp_q.push_back(0);
    end

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    task automatic check_all(input string req);
        int e;
        e = exp_q[$];
        check(req, int'(count), e);
        check("R8", int'(count_onehot == (OH'(1) << e)), 1);
    endtask

    // Compare on every falling clock edge, once the ripple has settled.
    always @(negedge clk) begin
        if (!done && exp_q.size() > 0) begin
            if (!clr_n) check_all("R1 R5");
            else check_all("R3");
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
            finish_run();
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        int prev;
        exp_q.push_back(0);
        #1 clr_n = 1'b0;
        // R1 / R5: edges during clear keep zero (checked at each negedge).
        repeat (3) @(negedge clk);
        check("R1", int'(count), 0);
        check("R1", int'(count_onehot), 1);
        #1 clr_n = 1'b1;
        @(negedge clk);
        check("R5", int'(count), MODV - 1);
        // Run through two full wraps; R2, R4 and R7 checked each cycle.
        for (int n = 0; n < 2 * MODV + 3; n++) begin
            prev = int'(count);
            @(negedge clk);
            check("R2", int'(count[0]), 1 - (prev & 1));
            if (prev == 0) check("R4", int'(count), MODV - 1);
            if ((prev & 1) == 1) check("R7", int'(count[W-1:1]), prev >> 1);
        end
        // R6: asynchronous clear mid-cycle, held across two edges.
        #1 clr_n = 1'b0;
        #0.5 check("R6", int'(count), 0);
        repeat (2) @(negedge clk);
        #1 clr_n = 1'b1;
        @(negedge clk);
        check("R5", int'(count), MODV - 1);
        repeat (5) @(negedge clk);
        // R6: short pulse entirely between two edges.
        #0.5 clr_n = 1'b0;
        #0.5 check("R6", int'(count), 0);
        check("R6", int'(count_onehot), 1);
        #0.5 clr_n = 1'b1;
        @(negedge clk);
        check("R4", int'(count), MODV - 1);
        repeat (20) @(negedge clk);
        #0.5 finish_run();
    end

endmodule